// File: doc/BRIEF.md
# Self-Timing Serial Port

This block is a full-duplex asynchronous serial port that has no baud setting at all. After reset, or after a relearn request, it waits for the far end to send a training character. It times the low pulse of that character's start bit with the system clock and keeps that count as the bit period. The receive sampler and the transmit serializer then both frame characters at that rate. The training character itself is thrown away. The far end must send one whose lowest data bit is a one, so that the start bit is the only low span that gets measured.

Each character on either wire is ten bit times long: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The idle line is high. The receive input passes through a two-stage synchronizer. The receiver then checks every bit at its midpoint: half a period after the falling edge for the start bit, then one full period later for each following bit. The host sends bytes through a valid/ready handshake and gets received bytes with a one-cycle strobe. Two status outputs show lock and a one-cycle framing error.

Top module: `autobaud_uart`

## Requirements
- R1: After reset, and in the cycle after `relearn_i` is sampled high, `locked_o` is 0, `tx_ready_o` is 0 and `txd_o` is 1 (mark); the stored period is cleared.
- R2: While unlocked, the first low span on the line that lasts at least `MIN_PERIOD` clock cycles (after the line has been seen high) is stored as the bit period P, in clock cycles, and `locked_o` rises; shorter low spans leave the port unlocked.
- R3: No byte is presented on `rx_valid_o` while unlocked, and the training character whose start bit set P is never delivered.
- R4: Once locked, a character is received as start (0), D0..D7 (bit 0 first), stop (1); when the stop bit samples high, `rx_data_o` carries the byte and `rx_valid_o` pulses for one cycle.
- R5: Each received bit is sampled floor(P/2) cycles into it; a low pulse that has ended by the start-bit midpoint is dropped with no byte and no error.
- R6: If the stop bit samples low, `frame_err_o` pulses for one cycle, no byte is delivered, and the receiver waits for a high line before it looks for the next start bit.
- R7: `tx_ready_o` is high only when the port is locked and the transmitter is idle; a held `tx_valid_i` starts nothing while unlocked and `txd_o` stays high.
- R8: A byte accepted on `tx_valid_i && tx_ready_o` is sent as start 0, D0..D7, stop 1, each bit lasting exactly P cycles, starting in the cycle after acceptance; `tx_ready_o` stays low for exactly 10·P cycles.
- R9: Reception and transmission run at the same time without affecting each other.
- R10: After a relearn, the next qualifying start bit sets a new P, and both directions use the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| relearn_i | input | 1 | Clears the stored period and forces a new measurement |
| rxd_i | input | 1 | Serial receive line, asynchronous, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter locked and idle, byte accepted when valid |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| frame_err_o | output | 1 | One-cycle strobe for a stop bit sampled low |
| locked_o | output | 1 | Bit period captured, port usable |

## Verification
On every cycle the embedded properties check several local rules. A relearn always drops lock. A stored period is never below the floor. Lock rises only after a low span ends. A delivered byte always follows a high stop sample, and an error always follows a low one. Delivery and error never coincide. An accepted transmit byte always begins with a low start bit and a lowered ready. Only the bench scenarios can show the end-to-end results: that the measured count matches the far end's bit time, that every byte value survives in both directions at the same time, that each transmitted bit lasts exactly P cycles, and that glitches, bad stop bits and relearning at new rates (including odd periods) behave as required.

// File: rtl/autobaud_pkg.sv
`timescale 1ns/1ps
package autobaud_pkg;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned FRAME_BITS = DATA_BITS + 2;

    typedef enum logic [1:0] {
        MT_WAIT_HIGH,
        MT_ARMED,
        MT_LOW,
        MT_LOCKED
    } meter_state_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_STOP,
        RS_WAIT_HIGH
    } rx_state_e;

    typedef enum logic {
        TS_IDLE,
        TS_BUSY
    } tx_state_e;
endpackage

// File: rtl/abu_period_meter.sv
`timescale 1ns/1ps
module abu_period_meter
    import autobaud_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             relearn_i,
    input  logic             line_i,
    output logic             locked_o,
    output logic [CNT_W-1:0] period_o,
    output logic             capture_o,
    output logic [CNT_W-1:0] capture_period_o
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] MAX_CNT = '1;

    typedef struct packed {
        meter_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
    } meter_regs_t;

    meter_regs_t q, d;

    always_comb begin
        d         = q;
        capture_o = 1'b0;
        if (relearn_i) begin
            d.state  = MT_WAIT_HIGH;
            d.cnt    = '0;
            d.period = '0;
        end else begin
            case (q.state)
                MT_WAIT_HIGH: begin
                    if (line_i) d.state = MT_ARMED;
                end
                MT_ARMED: begin
                    if (!line_i) begin
                        d.state = MT_LOW;
                        d.cnt   = ONE;
                    end
                end
                MT_LOW: begin
                    if (!line_i) begin
                        if (q.cnt == MAX_CNT) d.state = MT_WAIT_HIGH;
                        else                  d.cnt   = q.cnt + ONE;
                    end else if (q.cnt >= MIN_CNT) begin
                        d.state   = MT_LOCKED;
                        d.period  = q.cnt;
                        capture_o = 1'b1;
                    end else begin
                        d.state = MT_ARMED;
                    end
                end
                MT_LOCKED: ;
                default: d.state = MT_WAIT_HIGH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: MT_WAIT_HIGH, cnt: '0, period: '0};
        else        q <= d;
    end

    assign locked_o         = (q.state == MT_LOCKED);
    assign period_o         = q.period;
    assign capture_period_o = q.cnt;

    // R1
    relearn_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        relearn_i |=> !locked_o);

    // R2
    period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (period_o >= MIN_CNT));

    // R2
    lock_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(line_i) && !$past(line_i, 2)));
endmodule

// File: rtl/abu_rx_sampler.sv
`timescale 1ns/1ps
module abu_rx_sampler
    import autobaud_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    input  logic                 locked_i,
    input  logic                 capture_i,
    input  logic [CNT_W-1:0]     capture_period_i,
    input  logic [CNT_W-1:0]     period_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);
    localparam int unsigned      IDX_W    = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        rx_state_e            state;
        logic [CNT_W-1:0]     timer;
        logic [IDX_W-1:0]     bit_idx;
        logic [DATA_BITS-1:0] shift;
        logic                 discard;
        logic                 valid;
        logic                 ferr;
        logic [DATA_BITS-1:0] data;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [CNT_W-1:0] half_now, half_first;

    assign half_now   = period_i >> 1;
    assign half_first = capture_period_i >> 1;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        if (capture_i) begin
            // training character: skip through its data and stop bits
            d.state   = RS_DATA;
            d.timer   = half_first - ONE;
            d.bit_idx = '0;
            d.discard = 1'b1;
        end else if (!locked_i) begin
            d.state   = RS_IDLE;
            d.timer   = '0;
            d.discard = 1'b0;
        end else begin
            case (q.state)
                RS_IDLE: begin
                    if (!line_i) begin
                        d.state = RS_START;
                        d.timer = half_now - ONE;
                    end
                end
                RS_START: begin
                    if (q.timer == '0) begin
                        if (line_i) begin
                            d.state = RS_IDLE;
                        end else begin
                            d.state   = RS_DATA;
                            d.timer   = period_i - ONE;
                            d.bit_idx = '0;
                        end
                    end else begin
                        d.timer = q.timer - ONE;
                    end
                end
                RS_DATA: begin
                    if (q.timer == '0) begin
                        d.shift = {line_i, q.shift[DATA_BITS-1:1]};
                        d.timer = period_i - ONE;
                        if (q.bit_idx == LAST_BIT) d.state   = RS_STOP;
                        else                       d.bit_idx = q.bit_idx + 1'b1;
                    end else begin
                        d.timer = q.timer - ONE;
                    end
                end
                RS_STOP: begin
                    if (q.timer == '0) begin
                        d.discard = 1'b0;
                        if (line_i) begin
                            d.state = RS_IDLE;
                            if (!q.discard) begin
                                d.valid = 1'b1;
                                d.data  = q.shift;
                            end
                        end else begin
                            d.state = RS_WAIT_HIGH;
                            d.ferr  = 1'b1;
                        end
                    end else begin
                        d.timer = q.timer - ONE;
                    end
                end
                RS_WAIT_HIGH: begin
                    if (line_i) d.state = RS_IDLE;
                end
                default: d.state = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: RS_IDLE, timer: '0, bit_idx: '0, shift: '0,
                           discard: 1'b0, valid: 1'b0, ferr: 1'b0, data: '0};
        else        q <= d;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign ferr_o  = q.ferr;

    // R4
    deliver_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(line_i));

    // R6
    error_on_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |-> !$past(line_i));

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && ferr_o));

    // R3
    deliver_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(locked_i));
endmodule

// File: rtl/abu_tx_serializer.sv
`timescale 1ns/1ps
module abu_tx_serializer
    import autobaud_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 locked_i,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 valid_i,
    output logic                 ready_o,
    output logic                 txd_o
);
    localparam int unsigned       LEFT_W   = $clog2(FRAME_BITS);
    localparam logic [LEFT_W-1:0] LAST_IDX = LEFT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    typedef struct packed {
        tx_state_e             state;
        logic [FRAME_BITS-1:0] shift;
        logic [CNT_W-1:0]      timer;
        logic [CNT_W-1:0]      bit_len;
        logic [LEFT_W-1:0]     left;
    } tx_regs_t;

    tx_regs_t q, d;

    assign ready_o = (q.state == TS_IDLE) && locked_i;

    always_comb begin
        d = q;
        case (q.state)
            TS_IDLE: begin
                if (valid_i && ready_o) begin
                    d.state   = TS_BUSY;
                    d.shift   = {1'b1, data_i, 1'b0};
                    d.bit_len = period_i;
                    d.timer   = period_i - ONE;
                    d.left    = LAST_IDX;
                end
            end
            TS_BUSY: begin
                if (q.timer == '0) begin
                    if (q.left == '0) begin
                        d.state = TS_IDLE;
                    end else begin
                        d.shift = {1'b1, q.shift[FRAME_BITS-1:1]};
                        d.left  = q.left - 1'b1;
                        d.timer = q.bit_len - ONE;
                    end
                end else begin
                    d.timer = q.timer - ONE;
                end
            end
            default: d.state = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: TS_IDLE, shift: '1, timer: '0, bit_len: '0, left: '0};
        else        q <= d;
    end

    assign txd_o = (q.state == TS_BUSY) ? q.shift[0] : 1'b1;

    // R8
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (!txd_o && !ready_o));

    // R8
    mark_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(txd_o));

    // R7
    ready_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> locked_i);
endmodule

// File: rtl/autobaud_uart.sv
`timescale 1ns/1ps
module autobaud_uart
    import autobaud_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned MIN_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       relearn_i,
    input  logic       rxd_i,
    output logic       txd_o,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    output logic       tx_ready_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       frame_err_o,
    output logic       locked_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_q, sy_d;

    always_comb begin
        sy_d.s1 = rxd_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '{s1: 1'b1, s2: 1'b1};
        else        sy_q <= sy_d;
    end

    logic             line;
    logic             locked;
    logic             capture;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] capture_period;

    assign line = sy_q.s2;

    abu_period_meter #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) i_meter (
        .clk              (clk),
        .rst_n            (rst_n),
        .relearn_i        (relearn_i),
        .line_i           (line),
        .locked_o         (locked),
        .period_o         (period),
        .capture_o        (capture),
        .capture_period_o (capture_period)
    );

    abu_rx_sampler #(
        .CNT_W (CNT_W)
    ) i_rx (
        .clk              (clk),
        .rst_n            (rst_n),
        .line_i           (line),
        .locked_i         (locked),
        .capture_i        (capture),
        .capture_period_i (capture_period),
        .period_i         (period),
        .data_o           (rx_data_o),
        .valid_o          (rx_valid_o),
        .ferr_o           (frame_err_o)
    );

    abu_tx_serializer #(
        .CNT_W (CNT_W)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked_i (locked),
        .period_i (period),
        .data_i   (tx_data_i),
        .valid_i  (tx_valid_i),
        .ready_o  (tx_ready_o),
        .txd_o    (txd_o)
    );

    assign locked_o = locked;
endmodule

// File: tb/test_autobaud_uart.sv
`timescale 1ns/1ps
module test_autobaud_uart;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       relearn;
    logic       rxd;
    logic       txd_o;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready_o;
    logic [7:0] rx_data_o;
    logic       rx_valid_o;
    logic       frame_err_o;
    logic       locked_o;

    always #2.5 clk = ~clk;

    autobaud_uart i_autobaud_uart (
        .clk         (clk),
        .rst_n       (rst_n),
        .relearn_i   (relearn),
        .rxd_i       (rxd),
        .txd_o       (txd_o),
        .tx_data_i   (tx_data),
        .tx_valid_i  (tx_valid),
        .tx_ready_o  (tx_ready_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .frame_err_o (frame_err_o),
        .locked_o    (locked_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int rx_cnt  = 0;
    int ferr_cnt = 0;
    int exp_rx  = 0;
    logic [7:0] rx_last = 8'h00;

    always @(negedge clk) begin
        if (rx_valid_o) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data_o;
        end
        if (frame_err_o) ferr_cnt <= ferr_cnt + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic rx_send(input logic [7:0] v, input int b, input logic stop);
        logic [9:0] fr;
        fr = {stop, v, 1'b0};
        @(posedge clk); #1;
        for (int k = 0; k < 10; k++) begin
            rxd = fr[k];
            repeat (b) @(posedge clk);
            #1;
        end
        rxd = 1'b1;
    endtask

    task automatic rx_expect(input logic [7:0] v, input string req);
        repeat (4) @(negedge clk);
        exp_rx++;
        check(req, "received byte count", rx_cnt, exp_rx);
        check(req, "received byte value", int'(rx_last), int'(v));
    endtask

    task automatic tx_frame(input logic [7:0] v, input int b, input string req);
        logic [9:0] fr;
        int bad;
        fr  = {1'b1, v, 1'b0};
        bad = 0;
        @(negedge clk);
        while (!tx_ready_o) @(negedge clk);
        tx_data  = v;
        tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        for (int n = 0; n < 10 * b; n++) begin
            @(negedge clk);
            if (txd_o !== fr[n / b]) bad++;
            if (tx_ready_o !== 1'b0) bad++;
        end
        @(negedge clk);
        check(req, "tx line/ready mismatches in frame", bad, 0);
        check(req, "tx ready after 10 periods", int'(tx_ready_o), 1);
    endtask

    task automatic train(input int b, input logic [7:0] v, input string req);
        rx_send(v, b, 1'b1);
        repeat (4) @(negedge clk);
        check(req, "locked after training", int'(locked_o), 1);
        check("R3", "training byte not delivered", rx_cnt, exp_rx);
    endtask

    task automatic do_relearn();
        @(posedge clk); #1;
        relearn = 1'b1;
        @(posedge clk); #1;
        relearn = 1'b0;
        @(negedge clk);
        check("R1", "locked after relearn", int'(locked_o), 0);
        check("R1", "tx ready after relearn", int'(tx_ready_o), 0);
        check("R1", "txd after relearn", int'(txd_o), 1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    localparam logic [7:0] PAT [6] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h01, 8'h80};

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL all requirements: watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int bad;
        int r6_err0;
        rxd = 1'b1; tx_valid = 1'b0; tx_data = 8'h00; relearn = 1'b0; rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "locked after reset", int'(locked_o), 0);
        check("R1", "tx ready after reset", int'(tx_ready_o), 0);
        check("R1", "txd after reset", int'(txd_o), 1);
        check("R1", "rx valid after reset", int'(rx_valid_o), 0);

        // R7: held valid while unlocked starts nothing
        bad = 0;
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd_o !== 1'b1) bad++;
            if (tx_ready_o !== 1'b0) bad++;
        end
        tx_valid = 1'b0;
        check("R7", "activity while unlocked", bad, 0);

        // R2: short low pulse below the floor leaves the port unlocked
        @(posedge clk); #1 rxd = 1'b0;
        repeat (2) @(posedge clk); #1 rxd = 1'b1;
        repeat (20) @(negedge clk);
        check("R2", "locked after short pulse", int'(locked_o), 0);
        check("R3", "no byte while unlocked", rx_cnt, 0);

        // R2 training at 8 cycles per bit
        train(8, 8'h55, "R2");

        // R4/R8/R9: every byte value both ways at once
        for (int v = 0; v < 256; v++) begin
            fork
                rx_send(8'(v), 8, 1'b1);
                tx_frame(8'(v), 8, "R8");
            join
            rx_expect(8'(v), "R4");
        end
        check("R9", "bytes received during duplex sweep", rx_cnt, 256);
        check("R6", "no framing errors in sweep", ferr_cnt, 0);

        // R5: glitch shorter than half a period
        @(posedge clk); #1 rxd = 1'b0;
        repeat (2) @(posedge clk); #1 rxd = 1'b1;
        repeat (30) @(negedge clk);
        check("R5", "no byte from glitch", rx_cnt, exp_rx);
        check("R5", "no error from glitch", ferr_cnt, 0);
        rx_send(8'hA5, 8, 1'b1);
        rx_expect(8'hA5, "R5");

        // R6: stop bit low
        r6_err0 = ferr_cnt;
        rx_send(8'h3C, 8, 1'b0);
        repeat (20) @(negedge clk);
        check("R6", "framing error count", ferr_cnt, r6_err0 + 1);
        check("R6", "no byte on bad stop", rx_cnt, exp_rx);
        rx_send(8'hC3, 8, 1'b1);
        rx_expect(8'hC3, "R6");

        // R10: relearn at 13 cycles per bit
        do_relearn();
        train(13, 8'h0F, "R10");
        for (int i = 0; i < 6; i++) begin
            fork
                rx_send(PAT[i], 13, 1'b1);
                tx_frame(PAT[i], 13, "R10");
            join
            rx_expect(PAT[i], "R10");
        end

        // R10: relearn at an odd period of 5 cycles
        do_relearn();
        train(5, 8'hFD, "R10");
        for (int i = 0; i < 6; i++) begin
            fork
                rx_send(PAT[i], 5, 1'b1);
                tx_frame(PAT[i], 5, "R10");
            join
            rx_expect(PAT[i], "R10");
        end
        check("R6", "framing errors overall", ferr_cnt, 1);

        summary();
        $finish;
    end
endmodule